// File: doc/BRIEF.md
# Power-Fail Chip-Enable Write-Protect Controller

This block sits between an address decoder and an external static RAM and produces the conditioned active-low chip enable that the memory actually sees. It works from two digital inputs. The first is a power-fail flag that is already synchronous; it is high while the supply is below the selected trip level. The second is the raw active-low enable from the decoder. While the supply is good, the raw enable goes straight to the output through combinational logic. When a failure is flagged, an access already under way may finish. The controller gives that access a bounded time, counted in clock cycles, and then forces the output inactive. After the supply recovers, the output stays inactive for a fixed lockout interval so that the processor can settle before the memory is enabled again.

The analog trip comparators and the supply switch lie outside this block. A static tolerance-select bit only passes through to the comparator. The controller is a four-state machine:
- **PASS** (code 0): pass-through.
- **DRAIN** (code 1): completing an access.
- **HOLD** (code 2): write-protected.
- **RECOVER** (code 3): lockout timing.

The named transitions are:
- *fail_idle*: PASS to HOLD.
- *fail_busy*: PASS to DRAIN.
- *access_done*: DRAIN to HOLD.
- *drain_timeout*: DRAIN to HOLD.
- *power_back*: HOLD to RECOVER.
- *refail*: RECOVER to HOLD.
- *lockout_done*: RECOVER to PASS.

One shared cycle counter times both DRAIN and RECOVER.

Top module: `pfwp_ctrl`

## Requirements
- R1: In PASS with `pwr_fail`=0, `ce_cond_n` equals `ce_raw_n` in the same cycle, for both input values.
- R2: In PASS with `pwr_fail`=1 and `ce_raw_n`=1, `ce_cond_n` is 1, and the next state is HOLD (fail_idle).
- R3: In PASS with `pwr_fail`=1 and `ce_raw_n`=0, `ce_cond_n` stays 0 and the next state is DRAIN (fail_busy). In DRAIN, `ce_cond_n` follows `ce_raw_n`. In the first DRAIN cycle with `ce_raw_n`=1, the output is 1 and the next state is HOLD (access_done).
- R4: DRAIN lasts at most `WPT_CYCLES` cycles. If `ce_raw_n` is still 0 in the last of them, the next state is HOLD (drain_timeout), and `ce_cond_n` becomes 1 whatever `ce_raw_n` does.
- R5: In HOLD, `ce_cond_n` is 1 whatever `ce_raw_n` does, and the state stays HOLD while `pwr_fail`=1. DRAIN ignores `pwr_fail`.
- R6: The first HOLD cycle with `pwr_fail`=0 leads to RECOVER (power_back). RECOVER lasts exactly `REC_CYCLES` cycles with `ce_cond_n`=1, then gives PASS (lockout_done).
- R7: `pwr_fail`=1 in any RECOVER cycle gives HOLD next (refail). A later RECOVER interval again lasts the full `REC_CYCLES` cycles.
- R8: While `rst_n`=0, the state is RECOVER with the counter at zero. PASS is reached only after `REC_CYCLES` cycles with no failure.
- R9: `cmp_tol_sel` always equals `tol_sel`.
- R10: `state_o` reports the state as PASS=0, DRAIN=1, HOLD=2, RECOVER=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Synchronous flag, supply below trip level |
| ce_raw_n | input | 1 | Raw active-low chip enable from the decoder |
| tol_sel | input | 1 | Static tolerance-select bit (5 % or 10 %) |
| cmp_tol_sel | output | 1 | Tolerance select forwarded to the comparator |
| ce_cond_n | output | 1 | Conditioned active-low chip enable to the RAM |
| state_o | output | 2 | Current state code |

## Verification
Two events can fall in the same DRAIN cycle: the end of the access, when the raw enable rises, and expiry of the write-protect timeout. The bench sweeps the length of the access from zero cycles to beyond `WPT_CYCLES`, so the raw enable rises on every DRAIN cycle in turn, including the final one, where both exits apply at once. In each case it judges the cycle count spent with the output low and that the output goes high on the expected cycle. A second coincidence is a reasserted failure flag on the last RECOVER cycle. The bench provokes it and expects HOLD, not PASS, followed by a full new lockout.

// File: rtl/pfwp_pkg.sv
package pfwp_pkg;
    typedef enum logic [1:0] {
        ST_PASS    = 2'd0,
        ST_DRAIN   = 2'd1,
        ST_HOLD    = 2'd2,
        ST_RECOVER = 2'd3
    } pfwp_state_e;
endpackage

// File: rtl/pfwp_cycle_ctr.sv
module pfwp_cycle_ctr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    input  logic         advance,
    output logic [W-1:0] count
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (restart) begin
            count <= '0;
        end else if (advance) begin
            count <= count + W'(1);
        end
    end
endmodule

// File: rtl/pfwp_fsm.sv
module pfwp_fsm
    import pfwp_pkg::*;
#(
    parameter int WPT_CYCLES = 5,
    parameter int REC_CYCLES = 7,
    parameter int W          = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pwr_fail,
    input  logic         ce_raw_n,
    input  logic [W-1:0] count,
    output pfwp_state_e  state,
    output logic         restart,
    output logic         advance
);
    localparam logic [W-1:0] WPT_LAST = W'(WPT_CYCLES - 1);
    localparam logic [W-1:0] REC_LAST = W'(REC_CYCLES - 1);

    pfwp_state_e state_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_RECOVER;
        else        state <= state_n;
    end

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_PASS: begin
                if (pwr_fail) state_n = ce_raw_n ? ST_HOLD : ST_DRAIN;
            end
            ST_DRAIN: begin
                if (ce_raw_n || count == WPT_LAST) state_n = ST_HOLD;
            end
            ST_HOLD: begin
                if (!pwr_fail) state_n = ST_RECOVER;
            end
            ST_RECOVER: begin
                if (pwr_fail)               state_n = ST_HOLD;
                else if (count == REC_LAST) state_n = ST_PASS;
            end
            default: state_n = ST_HOLD;
        endcase
    end

    assign restart = (state_n != state);
    assign advance = (state == ST_DRAIN) || (state == ST_RECOVER);

    assert_drain_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN) |-> (int'(count) < WPT_CYCLES));
    assert_fail_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && pwr_fail && ce_raw_n) |=> (state == ST_HOLD));
    assert_refail_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER && pwr_fail) |=> (state == ST_HOLD && count == '0));
    assert_pass_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS) |-> ($past(state) == ST_PASS || $past(state) == ST_RECOVER));
    assert_hold_stay_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && pwr_fail) |=> (state == ST_HOLD));
endmodule

// File: rtl/pfwp_ce_gate.sv
module pfwp_ce_gate
    import pfwp_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  pfwp_state_e state,
    input  logic        pwr_fail,
    input  logic        ce_raw_n,
    output logic        ce_cond_n
);
    // output process
    always_comb begin
        unique case (state)
            ST_PASS, ST_DRAIN:    ce_cond_n = ce_raw_n;
            ST_HOLD, ST_RECOVER:  ce_cond_n = 1'b1;
            default:              ce_cond_n = 1'b1;
        endcase
    end

    assert_follow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PASS && !pwr_fail) |-> (ce_cond_n == ce_raw_n));
    assert_hold_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> ce_cond_n);
    assert_recover_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RECOVER) |-> ce_cond_n);
endmodule

// File: rtl/pfwp_ctrl.sv
module pfwp_ctrl
    import pfwp_pkg::*;
#(
    parameter int WPT_CYCLES = 12500,
    parameter int REC_CYCLES = 10000000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pwr_fail,
    input  logic       ce_raw_n,
    input  logic       tol_sel,
    output logic       cmp_tol_sel,
    output logic       ce_cond_n,
    output logic [1:0] state_o
);
    localparam int MAXC = (WPT_CYCLES > REC_CYCLES) ? WPT_CYCLES : REC_CYCLES;
    localparam int CW   = (MAXC < 2) ? 1 : $clog2(MAXC);

    pfwp_state_e    state;
    logic           restart;
    logic           advance;
    logic [CW-1:0]  count;

    pfwp_cycle_ctr #(.W(CW)) u_ctr (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .advance (advance),
        .count   (count)
    );

    pfwp_fsm #(.WPT_CYCLES(WPT_CYCLES), .REC_CYCLES(REC_CYCLES), .W(CW)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwr_fail (pwr_fail),
        .ce_raw_n (ce_raw_n),
        .count    (count),
        .state    (state),
        .restart  (restart),
        .advance  (advance)
    );

    pfwp_ce_gate u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .state     (state),
        .pwr_fail  (pwr_fail),
        .ce_raw_n  (ce_raw_n),
        .ce_cond_n (ce_cond_n)
    );

    assign cmp_tol_sel = tol_sel;
    assign state_o     = state;

    assert_tol_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_tol_sel == tol_sel);
endmodule

// File: tb/sim_pfwp_ctrl.sv
module sim_pfwp_ctrl;
    localparam int WPT = 5;
    localparam int REC = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_fail = 1'b0;
    logic ce_raw_n = 1'b1;
    logic tol_sel = 1'b0;
    logic cmp_tol_sel, ce_cond_n;
    logic [1:0] state_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    pfwp_ctrl #(.WPT_CYCLES(WPT), .REC_CYCLES(REC)) u0 (
        .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail), .ce_raw_n(ce_raw_n),
        .tol_sel(tol_sel), .cmp_tol_sel(cmp_tol_sel), .ce_cond_n(ce_cond_n),
        .state_o(state_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // advance one clock; inputs are driven and outputs sampled 2 ns after the edge
    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic recover_full(input string req);
        for (int i = 0; i < REC; i++) begin
            settle();
            chk({req, " state RECOVER"}, state_o, 3);
            chk({req, " ce high"}, ce_cond_n, 1);
            ce_raw_n = i[0];
            tick();
        end
        settle();
        chk({req, " back to PASS"}, state_o, 0);
    endtask

    initial begin
        #(8 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        ce_raw_n = 1'b0;
        #10;
        // R8: reset state
        chk("R8 reset state", state_o, 3);
        chk("R8 reset ce", ce_cond_n, 1);
        // R9: tolerance select passes through
        for (int t = 0; t < 2; t++) begin
            tol_sel = t[0];
            settle();
            chk("R9 tol pass", cmp_tol_sel, t);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        recover_full("R8 R6");

        // R1 / R10: pass-through both values
        for (int v = 0; v < 2; v++) begin
            ce_raw_n = v[0];
            settle();
            chk("R1 follow", ce_cond_n, v);
            chk("R10 pass code", state_o, 0);
        end

        // R2: failure while idle
        ce_raw_n = 1'b1; pwr_fail = 1'b1;
        settle();
        chk("R2 idle detect ce", ce_cond_n, 1);
        tick();
        for (int v = 0; v < 2; v++) begin
            ce_raw_n = v[0];
            settle();
            chk("R2 HOLD state", state_o, 2);
            chk("R5 HOLD ce", ce_cond_n, 1);
            tick();
        end
        pwr_fail = 1'b0;
        settle();
        chk("R6 power_back cycle", state_o, 2);
        tick();
        recover_full("R6");

        // R3 / R4 sweep: access length d after detection
        for (int d = 0; d <= WPT + 2; d++) begin
            ce_raw_n = 1'b0; pwr_fail = 1'b1;
            settle();
            chk("R3 detect busy ce", ce_cond_n, 0);
            tick();
            pwr_fail = (d % 2 == 0);   // DRAIN ignores the flag (R5)
            for (int i = 0; i < d && i < WPT; i++) begin
                settle();
                chk("R3 DRAIN state", state_o, 1);
                chk("R3 DRAIN ce low", ce_cond_n, 0);
                tick();
            end
            if (d < WPT) begin
                ce_raw_n = 1'b1;
                settle();
                chk("R3 access_done ce", ce_cond_n, 1);
                chk("R3 access_done state", state_o, 1);
                tick();
            end
            ce_raw_n = 1'b0;
            pwr_fail = 1'b1;
            settle();
            chk("R4 HOLD after drain", state_o, 2);
            chk("R4 ce forced", ce_cond_n, 1);
            tick();
            pwr_fail = 1'b0;
            tick();
            if (d == 2) begin
                // R7: refail on the last RECOVER cycle
                for (int i = 0; i < REC - 1; i++) tick();
                pwr_fail = 1'b1;
                settle();
                chk("R7 last recover state", state_o, 3);
                tick();
                settle();
                chk("R7 refail HOLD", state_o, 2);
                chk("R7 ce high", ce_cond_n, 1);
                pwr_fail = 1'b0;
                tick();
            end
            recover_full("R6 R7");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule